// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block runs the command protocol of a 32-bit flash array made of two 16-bit flash devices wired side by side, each device owning one half of the data bus. A host issues one of three operations through a request/response port: an identity check, the erase of the block that holds a given word address, or the programming of a single 32-bit word. The sequencer turns each request into the bus writes and reads the devices expect. Every command byte is written into both 16-bit lanes at once, so both devices always see the same command.

After an erase or a program has started, the block polls the status of both devices. It writes the status command and then reads the word, and it repeats this pair until both lanes report ready. It then puts the array back into read mode at the same address and reports the result. A programmed word also gets a read-back comparison. A configurable poll limit ends an operation that never becomes ready and reports a timeout. The flash side is a single-cycle synchronous bus: a strobe is held until the device drops its wait signal, and that cycle completes the transfer.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, req_ready_o is 1 while fl_we_o, fl_re_o and rsp_valid_o are 0.
- R2: Op code 0 (identity check) writes 0x00900090 at address 0, reads address 0 and then address 1, and writes 0x00FF00FF at address 0. It succeeds only when word 0 reads 0x00890089 and word 1 reads 0x88F388F3 or 0x88F488F4.
- R3: Op code 1 (erase) writes 0x00200020 and then 0x00D000D0 to the request address before any polling.
- R4: Each poll is a write of 0x00700070 to the operation address followed by a read of that address. Polling repeats while bit 7 or bit 23 of the read word is 0, and stops at the first read with both bits set.
- R5: When polling ends, 0x00FF00FF is written to the operation address before the response is given.
- R6: An erase fails when bit 5 or bit 21 of the final status word is 1, and succeeds otherwise.
- R7: Op code 2 (program) writes 0x00400040 and then the data word to the address, polls, returns to read mode, and reads the address back. It succeeds only if bits 4 and 20 of the final status are 0 and the read-back equals the data.
- R8: When a poll read still shows a lane busy after POLL_LIMIT polling cycles, the block stops polling, writes read-array, skips the read-back and responds with rsp_timeout_o=1 and rsp_ok_o=0.
- R9: From the accepting edge until the response cycle, req_ready_o is 0 and further requests are ignored. rsp_valid_o is a single-cycle pulse followed by req_ready_o=1.
- R10: Op code 3 makes no bus transfer and responds with rsp_ok_o=0 and rsp_timeout_o=0.
- R11: While a strobe is held and fl_wait_i is 1, the strobe, address and write data stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Operation request |
| req_ready_o | output | 1 | Idle, can accept a request |
| req_op_i | input | 2 | 0 identity, 1 erase, 2 program, 3 reserved |
| req_addr_i | input | ADDR_W | Word address |
| req_data_i | input | 32 | Word to program |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_ok_o | output | 1 | Operation succeeded |
| rsp_timeout_o | output | 1 | Poll limit reached |
| fl_addr_o | output | ADDR_W | Flash word address |
| fl_wdata_o | output | 32 | Flash write data |
| fl_we_o | output | 1 | Write strobe |
| fl_re_o | output | 1 | Read strobe |
| fl_rdata_i | input | 32 | Flash read data |
| fl_wait_i | input | 1 | Flash stall, extends the current transfer |

## Verification
The hardest situation to reach is a status read in which one lane is ready and the other is still busy, because only this case shows whether the block waits for both devices. The behavioural flash in the bench gives each lane its own busy countdown, with the upper lane finishing much later. It also stalls transfers with a pseudo-random wait pattern and can hold both lanes busy so that the timeout path runs. Each completed transfer is logged and checked against the expected command order, including where polling stops.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 16;
  localparam int DW     = LANES * LANE_W;

  typedef enum logic [1:0] {OP_PROBE = 2'd0, OP_ERASE = 2'd1, OP_PROG = 2'd2, OP_RSVD = 2'd3} op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ID_CMD, S_ID_MAN, S_ID_DEV, S_ERS_SET, S_ERS_CONF, S_PGM_SET,
    S_PGM_DATA, S_POLL_CMD, S_POLL_RD, S_RA_CMD, S_VERIFY, S_DONE
  } state_e;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_ID    = 8'h90;
  localparam logic [7:0] C_ERS_SET  = 8'h20;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_PGM_SET  = 8'h40;
  localparam logic [7:0] C_RD_STAT  = 8'h70;

  localparam int ST_RDY  = 7;
  localparam int ST_EERR = 5;
  localparam int ST_PERR = 4;

  localparam logic [DW-1:0] ID_MAN   = 32'h0089_0089;
  localparam logic [DW-1:0] ID_DEV_T = 32'h88F3_88F3;
  localparam logic [DW-1:0] ID_DEV_B = 32'h88F4_88F4;

  function automatic logic [DW-1:0] lanes_cmd(input logic [7:0] c);
    logic [DW-1:0] r;
    r = '0;
    for (int l = 0; l < LANES; l++) r[l*LANE_W +: 8] = c;
    return r;
  endfunction
endpackage

// File: rtl/nor_lane_status.sv
module nor_lane_status
  import nor_seq_pkg::*;
(
  input  logic [DW-1:0] word_i,
  output logic          all_ready_o,
  output logic          erase_err_o,
  output logic          prog_err_o
);
  logic [LANES-1:0] rdy, eerr, perr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdy[l]  = word_i[l*LANE_W + ST_RDY];
    assign eerr[l] = word_i[l*LANE_W + ST_EERR];
    assign perr[l] = word_i[l*LANE_W + ST_PERR];
  end

  assign all_ready_o = &rdy;
  assign erase_err_o = |eerr;
  assign prog_err_o  = |perr;
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (run_i && cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= LIM);

  // R8
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= LIM);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_timeout_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [31:0]       fl_wdata_o,
  output logic              fl_we_o,
  output logic              fl_re_o,
  input  logic [31:0]       fl_rdata_i,
  input  logic              fl_wait_i
);
  state_e            state_q, state_d;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic              man_ok_q, dev_ok_q, st_err_q, to_q, ok_q;
  logic              xfer, accept, all_rdy, ers_err, pgm_err, expired;

  nor_lane_status u_stat (
    .word_i(fl_rdata_i), .all_ready_o(all_rdy), .erase_err_o(ers_err), .prog_err_o(pgm_err)
  );

  nor_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
    .clk_i, .rst_ni,
    .clear_i(state_q == S_IDLE),
    .run_i(state_q == S_POLL_CMD || state_q == S_POLL_RD),
    .expired_o(expired)
  );

  assign req_ready_o   = (state_q == S_IDLE);
  assign accept        = req_valid_i && req_ready_o;
  assign rsp_valid_o   = (state_q == S_DONE);
  assign rsp_ok_o      = rsp_valid_o && ok_q;
  assign rsp_timeout_o = rsp_valid_o && to_q;
  assign xfer          = (fl_we_o || fl_re_o) && !fl_wait_i;

  // bus drive per state
  always_comb begin
    fl_we_o    = 1'b0;
    fl_re_o    = 1'b0;
    fl_addr_o  = addr_q;
    fl_wdata_o = '0;
    unique case (state_q)
      S_ID_CMD:   begin fl_we_o = 1'b1; fl_addr_o = '0; fl_wdata_o = lanes_cmd(C_RD_ID); end
      S_ID_MAN:   begin fl_re_o = 1'b1; fl_addr_o = '0; end
      S_ID_DEV:   begin fl_re_o = 1'b1; fl_addr_o = ADDR_W'(1); end
      S_ERS_SET:  begin fl_we_o = 1'b1; fl_wdata_o = lanes_cmd(C_ERS_SET); end
      S_ERS_CONF: begin fl_we_o = 1'b1; fl_wdata_o = lanes_cmd(C_CONFIRM); end
      S_PGM_SET:  begin fl_we_o = 1'b1; fl_wdata_o = lanes_cmd(C_PGM_SET); end
      S_PGM_DATA: begin fl_we_o = 1'b1; fl_wdata_o = data_q; end
      S_POLL_CMD: begin fl_we_o = 1'b1; fl_wdata_o = lanes_cmd(C_RD_STAT); end
      S_POLL_RD:  fl_re_o = 1'b1;
      S_RA_CMD: begin
        fl_we_o    = 1'b1;
        fl_wdata_o = lanes_cmd(C_RD_ARRAY);
        if (op_q == OP_PROBE) fl_addr_o = '0;
      end
      S_VERIFY:   fl_re_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        unique case (op_e'(req_op_i))
          OP_PROBE: state_d = S_ID_CMD;
          OP_ERASE: state_d = S_ERS_SET;
          OP_PROG:  state_d = S_PGM_SET;
          default:  state_d = S_DONE;
        endcase
      end
      S_ID_CMD:   if (xfer) state_d = S_ID_MAN;
      S_ID_MAN:   if (xfer) state_d = S_ID_DEV;
      S_ID_DEV:   if (xfer) state_d = S_RA_CMD;
      S_ERS_SET:  if (xfer) state_d = S_ERS_CONF;
      S_ERS_CONF: if (xfer) state_d = S_POLL_CMD;
      S_PGM_SET:  if (xfer) state_d = S_PGM_DATA;
      S_PGM_DATA: if (xfer) state_d = S_POLL_CMD;
      S_POLL_CMD: if (xfer) state_d = S_POLL_RD;
      S_POLL_RD:  if (xfer) state_d = (all_rdy || expired) ? S_RA_CMD : S_POLL_CMD;
      S_RA_CMD:   if (xfer) state_d = (op_q == OP_PROG && !to_q) ? S_VERIFY : S_DONE;
      S_VERIFY:   if (xfer) state_d = S_DONE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      op_q     <= OP_PROBE;
      addr_q   <= '0;
      data_q   <= '0;
      man_ok_q <= 1'b0;
      dev_ok_q <= 1'b0;
      st_err_q <= 1'b0;
      to_q     <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q     <= op_e'(req_op_i);
        addr_q   <= req_addr_i;
        data_q   <= req_data_i;
        st_err_q <= 1'b0;
        to_q     <= 1'b0;
        ok_q     <= 1'b0;
      end
      if (xfer) begin
        unique case (state_q)
          S_ID_MAN: man_ok_q <= (fl_rdata_i == ID_MAN);
          S_ID_DEV: dev_ok_q <= (fl_rdata_i == ID_DEV_T) || (fl_rdata_i == ID_DEV_B);
          S_POLL_RD: begin
            if (all_rdy)      st_err_q <= (op_q == OP_ERASE) ? ers_err : pgm_err;
            else if (expired) to_q     <= 1'b1;
          end
          S_RA_CMD: begin
            if (op_q == OP_PROBE)      ok_q <= man_ok_q && dev_ok_q;
            else if (op_q == OP_ERASE) ok_q <= !to_q && !st_err_q;
          end
          S_VERIFY: ok_q <= !st_err_q && (fl_rdata_i == data_q);
          default: ;
        endcase
      end
    end
  end

  // R11
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_we_o || fl_re_o) && fl_wait_i |=>
      $stable(fl_we_o) && $stable(fl_re_o) && $stable(fl_addr_o) && $stable(fl_wdata_o));
  // R9
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  // R8
  timeout_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_timeout_o |-> !rsp_ok_o);
  // R5
  ra_before_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (op_q == OP_ERASE || op_q == OP_PROBE) |->
      $past(fl_we_o && !fl_wait_i && fl_wdata_o == lanes_cmd(C_RD_ARRAY)));
  // R10
  no_bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !fl_we_o && !fl_re_o);
endmodule

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;
  localparam int AW = 20;
  localparam int PL = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_data = 0;
  logic rsp_valid, rsp_ok, rsp_to;
  logic [AW-1:0] fl_addr;
  logic [31:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re, fl_wait;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .POLL_LIMIT(PL)) u_nor_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok), .rsp_timeout_o(rsp_to),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_we_o(fl_we), .fl_re_o(fl_re),
    .fl_rdata_i(fl_rdata), .fl_wait_i(fl_wait)
  );

  // behavioural flash pair
  typedef enum {M_ARR, M_ID, M_ST} mmode_e;
  mmode_e mode = M_ARR;
  logic [31:0] mem [16];
  bit pend_e = 0, pend_p = 0;
  int busy_lo = 0, busy_hi = 0;
  bit ee_lo = 0, ee_hi = 0, pe_lo = 0, pe_hi = 0;
  bit inj_ee_hi = 0, inj_pe_lo = 0, inj_corrupt = 0, inj_stuck = 0;
  int dly_lo = 2, dly_hi = 2;
  logic [31:0] dev_word = 32'h88F3_88F3;
  bit wait_en = 1;
  logic [7:0] lfsr = 8'h5A;

  function automatic logic [15:0] lane_st(bit rdy, bit ee, bit pe);
    return {8'h00, rdy, 1'b0, ee, pe, 4'h0};
  endfunction

  function automatic logic [31:0] cmdw(logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction

  always_comb begin
    fl_rdata = '0;
    case (mode)
      M_ID:  fl_rdata = (fl_addr == 0) ? 32'h0089_0089 : (fl_addr == 1) ? dev_word : 32'h0;
      M_ST:  fl_rdata = {lane_st(busy_hi == 0 && !inj_stuck, ee_hi, pe_hi),
                         lane_st(busy_lo == 0 && !inj_stuck, ee_lo, pe_lo)};
      default: fl_rdata = mem[fl_addr[3:0]];
    endcase
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    fl_wait <= wait_en && lfsr[0];
  end
  initial fl_wait = 0;

  always @(posedge clk) begin
    if (busy_lo > 0) busy_lo <= busy_lo - 1;
    if (busy_hi > 0) busy_hi <= busy_hi - 1;
    if (fl_we && !fl_wait) begin
      if (pend_p) begin
        mem[fl_addr[3:0]] <= (mem[fl_addr[3:0]] & fl_wdata) ^ {31'b0, inj_corrupt};
        pend_p <= 0; mode <= M_ST; busy_lo <= dly_lo; busy_hi <= dly_hi;
        pe_lo <= inj_pe_lo; pe_hi <= 0; ee_lo <= 0; ee_hi <= 0;
      end else if (pend_e && fl_wdata == cmdw(8'hD0)) begin
        mem[fl_addr[3:0]] <= '1;
        pend_e <= 0; mode <= M_ST; busy_lo <= dly_lo; busy_hi <= dly_hi;
        ee_lo <= 0; ee_hi <= inj_ee_hi; pe_lo <= 0; pe_hi <= 0;
      end else begin
        pend_e <= 0;
        case (fl_wdata[7:0])
          8'hFF: mode <= M_ARR;
          8'h90: mode <= M_ID;
          8'h70: mode <= M_ST;
          8'h20: pend_e <= 1;
          8'h40: pend_p <= 1;
          default: ;
        endcase
      end
    end
  end

  // transfer log
  typedef struct { bit we; int addr; logic [31:0] wd; logic [31:0] rd; } xfer_t;
  xfer_t log_q[$];
  always @(posedge clk) if (rst_n && (fl_we || fl_re) && !fl_wait)
    log_q.push_back('{fl_we, int'(fl_addr), fl_wdata, fl_rdata});

  task automatic chk(bit cond, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit ent(int i, bit we, int a, bit cw, logic [31:0] wd);
    if (i >= log_q.size()) return 0;
    if (log_q[i].we != we || log_q[i].addr != a) return 0;
    if (cw && log_q[i].wd != wd) return 0;
    return 1;
  endfunction

  // kind 0 erase, 1 program, 2 probe
  task automatic check_seq(int kind, int a, logic [31:0] d, bit exp_to, string tag);
    int i = 0; bit good = 1; bit last_rdy = 0; int polls = 0;
    if (kind == 2) begin
      good = ent(0, 1, 0, 1, cmdw(8'h90)) && ent(1, 0, 0, 0, 0) && ent(2, 0, 1, 0, 0)
          && ent(3, 1, 0, 1, cmdw(8'hFF)) && log_q.size() == 4;
    end else begin
      good = ent(0, 1, a, 1, kind == 0 ? cmdw(8'h20) : cmdw(8'h40))
          && ent(1, 1, a, 1, kind == 0 ? cmdw(8'hD0) : d);
      i = 2;
      while (good && ent(i, 1, a, 1, cmdw(8'h70))) begin
        if (!ent(i + 1, 0, a, 0, 0)) good = 0;
        else begin
          if (last_rdy) good = 0;  // polled again after both lanes ready
          last_rdy = log_q[i+1].rd[7] && log_q[i+1].rd[23];
        end
        polls++; i += 2;
      end
      if (polls == 0 || last_rdy == exp_to) good = 0;
      if (!ent(i, 1, a, 1, cmdw(8'hFF))) good = 0;
      i++;
      if (kind == 1 && !exp_to) begin
        if (!ent(i, 0, a, 0, 0)) good = 0;
        i++;
      end
      if (i != log_q.size()) good = 0;
    end
    chk(good, tag, "bus sequence len", log_q.size(), i);
  endtask

  task automatic run_op(logic [1:0] op, int a, logic [31:0] d, bit noise, output bit ok, output bit to);
    int n = 0;
    log_q.delete();
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = noise; req_op = 2'd2; req_addr = AW'(9);
    forever begin
      if (rsp_valid) break;
      // R9 ready held low while busy
      chk(req_ready == 0, "R9", "ready during op", req_ready, 0);
      n++;
      if (n > 5000) break;
      @(negedge clk);
      req_valid = noise;
    end
    ok = rsp_ok; to = rsp_to;
    chk(rsp_valid == 1, "R9", "response seen", rsp_valid, 1);
    req_valid = 0;
    @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 1, "R9", "pulse then ready", {rsp_valid, req_ready}, 2'b01);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R0 watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ok, to;
    for (int k = 0; k < 16; k++) mem[k] = '1;
    repeat (4) @(negedge clk);
    // R1
    chk(req_ready == 1 && !fl_we && !fl_re && !rsp_valid, "R1", "reset outputs",
        {req_ready, fl_we, fl_re, rsp_valid}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);

    // R2 identity check variants
    dev_word = 32'h88F3_88F3;
    run_op(2'd0, 7, 0, 0, ok, to);
    chk(ok && !to, "R2", "probe top ok", {ok, to}, 2'b10);
    check_seq(2, 0, 0, 0, "R2");
    dev_word = 32'h88F4_88F4;
    run_op(2'd0, 0, 0, 1, ok, to);
    chk(ok, "R2", "probe bottom ok", ok, 1);
    dev_word = 32'h88F1_88F1;
    run_op(2'd0, 0, 0, 0, ok, to);
    chk(!ok, "R2", "probe wrong device", ok, 0);
    check_seq(2, 0, 0, 0, "R2");

    // R3 R4 R5 erase, upper lane finishes late, competing request held (R9)
    mem[3] = 32'h0;
    dly_lo = 3; dly_hi = 14;
    run_op(2'd1, 3, 0, 1, ok, to);
    chk(ok && !to, "R3", "erase ok", {ok, to}, 2'b10);
    check_seq(0, 3, 0, 0, "R4");
    chk(mem[3] == 32'hFFFF_FFFF, "R3", "block erased", mem[3], 32'hFFFF_FFFF);
    chk(mem[9] == 32'hFFFF_FFFF, "R9", "ignored request untouched", mem[9], 32'hFFFF_FFFF);
    chk(mode == M_ARR, "R5", "array mode after", mode, M_ARR);

    // R6 erase error in upper lane, lower lane late
    dly_lo = 10; dly_hi = 1; inj_ee_hi = 1;
    run_op(2'd1, 5, 0, 0, ok, to);
    chk(!ok && !to, "R6", "erase error", {ok, to}, 2'b00);
    check_seq(0, 5, 0, 0, "R6");
    inj_ee_hi = 0;

    // R7 program
    mem[6] = '1;
    run_op(2'd2, 6, 32'h1234_ABCD, 0, ok, to);
    chk(ok && !to, "R7", "program ok", {ok, to}, 2'b10);
    check_seq(1, 6, 32'h1234_ABCD, 0, "R7");
    chk(mem[6] == 32'h1234_ABCD, "R7", "word stored", mem[6], 32'h1234_ABCD);
    inj_pe_lo = 1;
    run_op(2'd2, 8, 32'h0F0F_0F0F, 0, ok, to);
    chk(!ok, "R7", "program error bit", ok, 0);
    inj_pe_lo = 0;
    inj_corrupt = 1;
    run_op(2'd2, 10, 32'h5555_AAAA, 0, ok, to);
    chk(!ok, "R7", "read-back mismatch", ok, 0);
    check_seq(1, 10, 32'h5555_AAAA, 0, "R7");
    inj_corrupt = 0;

    // R8 timeouts
    inj_stuck = 1;
    run_op(2'd1, 2, 0, 0, ok, to);
    chk(!ok && to, "R8", "erase timeout", {ok, to}, 2'b01);
    check_seq(0, 2, 0, 1, "R8");
    run_op(2'd2, 4, 32'hCAFE_0001, 0, ok, to);
    chk(!ok && to, "R8", "program timeout", {ok, to}, 2'b01);
    check_seq(1, 4, 32'hCAFE_0001, 1, "R8");
    inj_stuck = 0;

    // R10 reserved op
    run_op(2'd3, 1, 0, 0, ok, to);
    chk(!ok && !to, "R10", "reserved result", {ok, to}, 2'b00);
    chk(log_q.size() == 0, "R10", "no transfers", log_q.size(), 0);

    // R11 no stalls, back-to-back transfers
    wait_en = 0; dly_lo = 0; dly_hi = 0;
    run_op(2'd1, 12, 0, 0, ok, to);
    chk(ok, "R11", "erase without wait", ok, 1);
    check_seq(0, 12, 0, 0, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule